// File: doc/BRIEF.md
# SMBus Master Clock and Data Edge Timer

This block paces the bit-level waveform of a two-wire bus master. The SCL low and high phases are counted in pulses of an external clock-source overflow strobe, not in raw system clocks, so a configured default of two ticks low and four ticks high gives a high phase about twice the low phase. The high count starts only once the SCL line is sampled high. A slave that stretches the clock, or another master that holds the line down, therefore lengthens the period and can never shorten it.

SDA is moved a fixed number of system clocks after each SCL fall. In standard mode the hold is 3 clocks, and the setup before the next SCL rise is whatever remains of the low phase. In extended mode the hold grows to 12 clocks, and SCL stays low until SDA has been stable for at least 11 clocks, even if the low-phase tick count has already run out. The mode is taken at each SCL fall. Both lines are driven as open-drain pull-down enables. A one-cycle strobe marks every bit boundary, so an upstream byte engine can present the next data bit.

Top module: `smb_bit_timer`

## Requirements
- R1: During and right after reset, `sclPullLow`, `sdaPullLow` and `bitStrobe` are all 0, which leaves both lines released.
- R2: Once SCL is pulled low, it stays low for at least `LOW_TICKS` pulses of `srcTick`.
- R3: The high phase ends after `HIGH_TICKS` pulses of `srcTick` that arrive while `sclIn` is 1. Pulses that arrive while the line is held low by another device are not counted, and no bit boundary occurs during such a hold.
- R4: `bitStrobe` is a one-cycle pulse in the first cycle in which `sclPullLow` is 1.
- R5: With `extHold` = 0 latched, `sdaPullLow` takes its new value exactly 3 clocks after `sclPullLow` rises, and keeps its old value before that.
- R6: With `extHold` = 1 latched, the SDA change happens exactly 12 clocks after `sclPullLow` rises.
- R7: SCL is never released before SDA has changed. With extended mode latched, SCL is released no earlier than 11 clocks after the SDA change.
- R8: `extHold` is sampled in the cycle SCL is pulled low. Changing it later in the same low phase has no effect on that bit's timing.
- R9: Between two bit boundaries, at least `LOW_TICKS + HIGH_TICKS` source ticks elapse.
- R10: The data bit is encoded on the line so that a 0 asserts `sdaPullLow` and a 1 releases it. `dataBit` is sampled at the SDA change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 1 | One-cycle overflow pulse of the bit-rate clock source |
| sclIn | input | 1 | Sampled level of the SCL line |
| extHold | input | 1 | 1 selects extended SDA setup and hold |
| dataBit | input | 1 | Next bit to place on SDA |
| sclPullLow | output | 1 | 1 pulls SCL low |
| sdaPullLow | output | 1 | 1 pulls SDA low |
| bitStrobe | output | 1 | Pulse at each bit boundary (SCL fall) |

## Verification
The bench goes after the off-by-one edges of the hold delay. It checks that SDA is unchanged one clock before the 3- or 12-clock mark and correct on it, so a hold counter that is short or long by one shows up at once. Fast tick rates make the low-phase count expire before SDA has moved. A design that released SCL on ticks alone would then raise SCL with no setup time at all, and in extended mode with less than 11 clocks of setup. Long stretches hold SCL low through several ticks. A design that counted those ticks would emit a bit boundary during the stretch and shorten the high phase. Flipping `extHold` in mid-bit catches a design that reads the mode continuously instead of latching it.

// File: rtl/smb_timer_pkg.sv
`timescale 1ns/1ps
package smb_timer_pkg;

  // Phase of the SCL waveform
  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,  // line released and seen high, counting high ticks
    PH_LOW  = 2'd1,  // line pulled low, counting low ticks and SDA timing
    PH_REL  = 2'd2   // line released, waiting for it to read high
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic phaseClr;   // clear the phase tick counter
    logic phaseInc;   // count one source tick
    logic sdaLaunch;  // SCL falls now: start the SDA hold timer
    logic lowEnd;     // SCL is released now
  } ctrl_strb_t;

endpackage

// File: rtl/smb_timer_dp.sv
`timescale 1ns/1ps
module smb_timer_dp
  import smb_timer_pkg::*;
#(
  parameter int LOW_TICKS  = 2,
  parameter int HIGH_TICKS = 4,
  parameter int HOLD_STD   = 3,
  parameter int HOLD_EXT   = 12,
  parameter int SETUP_EXT  = 11,
  parameter int CW = $clog2(((LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS) + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strb_t    strb,
  input  logic          extHold,
  input  logic          dataBit,
  output logic [CW-1:0] phaseCnt,
  output logic          lowDone,
  output logic          highDone,
  output logic          setupOk,
  output logic          sdaPullLow,
  output logic          modeExt,
  output logic          sdaUpd
);

  localparam int HOLD_MAX = (HOLD_EXT > HOLD_STD) ? HOLD_EXT : HOLD_STD;
  localparam int HW = $clog2(HOLD_MAX + 2);
  localparam int SW = $clog2(SETUP_EXT + 2);

  logic          holdRun;
  logic [HW-1:0] holdCnt;
  logic [HW-1:0] holdTarget;
  logic          holdHit;
  logic [SW-1:0] setupCnt;
  logic          sdaLevel;

  // Phase tick counter, shared by the low and high phases
  always_ff @(posedge clk) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strb.phaseClr) phaseCnt <= '0;
    else if (strb.phaseInc) phaseCnt <= phaseCnt + CW'(1);
  end

  assign lowDone  = (phaseCnt >= CW'(LOW_TICKS));
  assign highDone = (phaseCnt >= CW'(HIGH_TICKS));

  // Hold timer: the mode is latched when SCL falls
  assign holdTarget = modeExt ? HW'(HOLD_EXT) : HW'(HOLD_STD);
  assign holdHit    = holdRun && (holdCnt == holdTarget - HW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdRun  <= 1'b0;
      holdCnt  <= '0;
      modeExt  <= 1'b0;
      sdaUpd   <= 1'b0;
      sdaLevel <= 1'b1;
    end else if (strb.sdaLaunch) begin
      holdRun  <= 1'b1;
      holdCnt  <= '0;
      modeExt  <= extHold;
      sdaUpd   <= 1'b0;
    end else if (holdHit) begin
      holdRun  <= 1'b0;
      sdaUpd   <= 1'b1;
      sdaLevel <= dataBit;
    end else if (holdRun) begin
      holdCnt  <= holdCnt + HW'(1);
    end
  end

  // Setup timer: clocks of SDA stability since the change
  always_ff @(posedge clk) begin
    if (!rstN)                                 setupCnt <= '0;
    else if (holdHit)                          setupCnt <= '0;
    else if (sdaUpd && setupCnt != SW'(SETUP_EXT)) setupCnt <= setupCnt + SW'(1);
  end

  assign setupOk    = sdaUpd && (!modeExt || setupCnt >= SW'(SETUP_EXT - 1));
  assign sdaPullLow = !sdaLevel;

  // R7: control may only release SCL once the SDA change has happened
  a_r7_release_after_sda: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowEnd |-> sdaUpd && !holdRun);

  // R2: release never comes before the low tick budget is used up
  a_r2_low_budget: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowEnd |-> phaseCnt >= CW'(LOW_TICKS));

endmodule

// File: rtl/smb_timer_ctrl.sv
`timescale 1ns/1ps
module smb_timer_ctrl
  import smb_timer_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcTick,
  input  logic          sclIn,
  input  logic [CW-1:0] phaseCnt,
  input  logic          lowDone,
  input  logic          highDone,
  input  logic          setupOk,
  output ctrl_strb_t    strb,
  output logic          sclPullLow,
  output logic          bitStrobe
);

  phase_e phase, phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    unique case (phase)
      PH_HIGH: begin
        if (highDone) begin
          phaseNext      = PH_LOW;
          strb.phaseClr  = 1'b1;
          strb.sdaLaunch = 1'b1;
        end else if (srcTick && sclIn) begin
          strb.phaseInc  = 1'b1;
        end
      end
      PH_LOW: begin
        if (lowDone && setupOk) begin
          phaseNext     = PH_REL;
          strb.phaseClr = 1'b1;
          strb.lowEnd   = 1'b1;
        end else if (srcTick && !lowDone) begin
          strb.phaseInc = 1'b1;
        end
      end
      PH_REL: begin
        if (sclIn) begin
          phaseNext     = PH_HIGH;
          strb.phaseClr = 1'b1;
        end
      end
      default: phaseNext = PH_REL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_HIGH;
      bitStrobe <= 1'b0;
    end else begin
      phase     <= phaseNext;
      bitStrobe <= strb.sdaLaunch;
    end
  end

  assign sclPullLow = (phase == PH_LOW);

  // R3: a held-low line freezes the high count
  a_r3_freeze_when_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && !sclIn && !highDone) |=> $stable(phaseCnt));

  // R4: the bit boundary pulse coincides with the first pulled-low cycle
  a_r4_strobe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> sclPullLow && !$past(sclPullLow));

endmodule

// File: rtl/smb_bit_timer.sv
`timescale 1ns/1ps
module smb_bit_timer
  import smb_timer_pkg::*;
#(
  parameter int LOW_TICKS  = 2,
  parameter int HIGH_TICKS = 4,
  parameter int HOLD_STD   = 3,
  parameter int HOLD_EXT   = 12,
  parameter int SETUP_EXT  = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcTick,
  input  logic sclIn,
  input  logic extHold,
  input  logic dataBit,
  output logic sclPullLow,
  output logic sdaPullLow,
  output logic bitStrobe
);

  localparam int CW = $clog2(((LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS) + 1);
  localparam int PERIOD_TICKS = LOW_TICKS + HIGH_TICKS;
  localparam int TW = $clog2(PERIOD_TICKS + 2);
  localparam int AW = $clog2(HOLD_EXT + SETUP_EXT + 4);

  ctrl_strb_t    strb;
  logic [CW-1:0] phaseCnt;
  logic          lowDone, highDone, setupOk, modeExt, sdaUpd;

  smb_timer_ctrl #(.CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .sclIn(sclIn),
    .phaseCnt(phaseCnt), .lowDone(lowDone), .highDone(highDone),
    .setupOk(setupOk), .strb(strb), .sclPullLow(sclPullLow),
    .bitStrobe(bitStrobe)
  );

  smb_timer_dp #(
    .LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS), .HOLD_STD(HOLD_STD),
    .HOLD_EXT(HOLD_EXT), .SETUP_EXT(SETUP_EXT), .CW(CW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .extHold(extHold), .dataBit(dataBit),
    .phaseCnt(phaseCnt), .lowDone(lowDone), .highDone(highDone),
    .setupOk(setupOk), .sdaPullLow(sdaPullLow), .modeExt(modeExt),
    .sdaUpd(sdaUpd)
  );

  // Observation counters for port-level properties
  logic [AW-1:0] fallAge, setupAge;
  logic [TW-1:0] rateTicks, lowTicks;
  logic          seenBoundary;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallAge      <= '0;
      setupAge     <= '0;
      rateTicks    <= '0;
      lowTicks     <= '0;
      seenBoundary <= 1'b0;
    end else begin
      fallAge  <= bitStrobe ? AW'(1) : ((&fallAge) ? fallAge : fallAge + AW'(1));
      setupAge <= !sdaUpd ? '0 : ((&setupAge) ? setupAge : setupAge + AW'(1));
      if (bitStrobe) begin
        rateTicks    <= TW'(srcTick);
        lowTicks     <= TW'(srcTick);
        seenBoundary <= 1'b1;
      end else begin
        if (srcTick && rateTicks != TW'(PERIOD_TICKS)) rateTicks <= rateTicks + TW'(1);
        if (sclPullLow && srcTick && lowTicks != TW'(PERIOD_TICKS)) lowTicks <= lowTicks + TW'(1);
      end
    end
  end

  // R5 and R6: SDA moves exactly at the hold mark of the latched mode
  a_r5_r6_hold_mark: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |->
      fallAge == (modeExt ? AW'(HOLD_EXT) : AW'(HOLD_STD)));

  // R7: extended mode keeps SDA stable long enough before SCL rises
  a_r7_ext_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclPullLow) && modeExt) |-> setupAge >= AW'(SETUP_EXT));

  // R2: low phase spans the full low tick budget
  a_r2_low_ticks: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclPullLow) |-> lowTicks >= TW'(LOW_TICKS));

  // R9: bit rate never exceeds the configured period
  a_r9_no_overrate: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && seenBoundary) |-> rateTicks >= TW'(PERIOD_TICKS));

endmodule

// File: tb/smb_bit_timer_tb_top.sv
`timescale 1ns/1ps
module smb_bit_timer_tb_top;

  localparam int LOW_T   = 2;
  localparam int HIGH_T  = 4;
  localparam int HOLD_S  = 3;
  localparam int HOLD_E  = 12;
  localparam int SETUP_E = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcTick = 1'b0;
  logic extHold = 1'b0;
  logic dataBit = 1'b1;
  logic stretch = 1'b0;
  logic sclIn;
  logic sclPullLow, sdaPullLow, bitStrobe;

  int checks = 0;
  int errors = 0;
  int tickDiv = 6;
  int divCnt = 0;

  typedef struct {
    logic bitv;
    logic ext;
    logic flip;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  assign sclIn = !sclPullLow && !stretch;

  smb_bit_timer dut_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .sclIn(sclIn),
    .extHold(extHold), .dataBit(dataBit), .sclPullLow(sclPullLow),
    .sdaPullLow(sdaPullLow), .bitStrobe(bitStrobe)
  );

  // Source tick generator, updated away from the active edge
  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) begin
      divCnt  <= 0;
      srcTick <= 1'b1;
    end else begin
      divCnt  <= divCnt + 1;
      srcTick <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: push the expected bit, then steer the inputs around its boundary
  task automatic sendBit(input logic b, input logic ext, input logic flip,
                         input int stretchN);
    item_t it;
    int seenStrobe;
    it.bitv = b; it.ext = ext; it.flip = flip;
    extHold = ext;
    dataBit = b;
    expQ.push_back(it);
    do @(negedge clk); while (!bitStrobe);
    if (flip) extHold = !ext;
    if (stretchN > 0) stretch = 1'b1;
    do @(negedge clk); while (sclPullLow);
    if (stretchN > 0) begin
      seenStrobe = 0;
      repeat (stretchN) begin
        @(negedge clk);
        if (bitStrobe) seenStrobe++;
      end
      stretch = 1'b0;
      check(seenStrobe == 0, "R3", "boundaries during stretch", seenStrobe, 0);
    end
  endtask

  // Monitor: pop an expected bit at each boundary and time the SDA and SCL edges
  initial begin : monitor
    item_t it;
    logic  oldSda;
    int k, lowTicks, hold, minSetup;
    string tag;
    forever begin
      @(negedge clk);
      if (rstN && bitStrobe && expQ.size() > 0) begin
        it = expQ.pop_front();
        oldSda = sdaPullLow;
        check(sclPullLow == 1'b1, "R4", "scl pulled at strobe", sclPullLow, 1);
        hold = it.ext ? HOLD_E : HOLD_S;
        minSetup = it.ext ? SETUP_E : 1;
        tag = it.flip ? "R8" : (it.ext ? "R6" : "R5");
        k = 0;
        lowTicks = 0;
        forever begin
          @(negedge clk);
          k++;
          if (srcTick) lowTicks++;
          if (k == hold - 1)
            check(sdaPullLow == oldSda, tag, "sda before hold mark", sdaPullLow, oldSda);
          if (k == hold)
            check(sdaPullLow == !it.bitv, it.flip ? "R8" : "R10", "sda at hold mark",
                  sdaPullLow, !it.bitv);
          if (!sclPullLow || k > 500) break;
        end
        check(k - hold >= minSetup, "R7", "setup clocks", k - hold, minSetup);
        check(lowTicks >= LOW_T, "R2", "low phase ticks", lowTicks, LOW_T);
      end
    end
  end

  // High phase and period monitor
  initial begin : periodMon
    int hiTicks, rateTicks;
    bit seen, prevRel, prevIn;
    hiTicks = 0; rateTicks = 0; seen = 0; prevRel = 1; prevIn = 1;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        hiTicks = 0; rateTicks = 0; seen = 0;
      end else begin
        if (srcTick) rateTicks++;
        if (srcTick && prevRel && prevIn) hiTicks++;
        if (bitStrobe) begin
          check(hiTicks >= HIGH_T, "R3", "high ticks with line high", hiTicks, HIGH_T);
          if (seen)
            check(rateTicks >= LOW_T + HIGH_T, "R9", "ticks per bit", rateTicks, LOW_T + HIGH_T);
          seen = 1;
          hiTicks = 0;
          rateTicks = 0;
        end
      end
      prevRel = !sclPullLow;
      prevIn  = sclIn;
    end
  end

  initial begin : mainSeq
    fork
      begin
        repeat (4) @(negedge clk);
        check({sclPullLow, sdaPullLow, bitStrobe} == 3'b000, "R1", "outputs in reset",
              {sclPullLow, sdaPullLow, bitStrobe}, 0);
        rstN = 1'b1;
        @(negedge clk);
        check({sclPullLow, sdaPullLow, bitStrobe} == 3'b000, "R1", "outputs after reset",
              {sclPullLow, sdaPullLow, bitStrobe}, 0);
        // standard and extended timing at a slow tick
        sendBit(1'b0, 1'b0, 1'b0, 0);
        sendBit(1'b1, 1'b0, 1'b0, 0);
        sendBit(1'b0, 1'b1, 1'b0, 0);
        sendBit(1'b1, 1'b1, 1'b0, 0);
        // mode change inside the low phase
        sendBit(1'b0, 1'b0, 1'b1, 0);
        sendBit(1'b1, 1'b1, 1'b1, 0);
        // clock stretching
        sendBit(1'b0, 1'b0, 1'b0, 40);
        sendBit(1'b1, 1'b1, 1'b0, 25);
        // tick every clock: SDA timing dominates the low phase
        tickDiv = 1;
        sendBit(1'b0, 1'b0, 1'b0, 0);
        sendBit(1'b1, 1'b0, 1'b0, 0);
        sendBit(1'b0, 1'b1, 1'b0, 0);
        tickDiv = 3;
        sendBit(1'b1, 1'b0, 1'b0, 10);
        sendBit(1'b0, 1'b1, 1'b0, 0);
        sendBit(1'b1, 1'b0, 1'b0, 0);
        repeat (200) @(negedge clk);
      end
      begin
        repeat (100000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule